// File: doc/BRIEF.md
# Interval Timer Programming Front End

This block sits between a byte-wide host write path and a three-channel interval timer. The host writes 8-bit values either to a shared control port or to one of three per-channel data ports. A control word names one channel and stores that channel's counting mode and its byte-access format. Later data writes to that channel are gathered into a 16-bit initial count according to the stored format. Each completed count is presented together with a single-cycle load strobe for the counter that consumes it.

A channel accepts no data until it has received a control word after reset. In two-byte format, a per-channel toggle tracks whether the next byte is the low half or the high half. Any control word addressed to that channel returns the toggle to the low half. Count writes never alter the stored mode.

Top module: `tmr_prog_if`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every strobe is 0, every count is 0x0000, every mode is 0 and every format is 00.
- R2: A write with `wr_sel`=3 is a control word. Bits 7:6 pick the channel (0, 1 or 2). Bits 5:4 become that channel's format (01 low byte only, 10 high byte only, 11 low then high). Bits 3:1 become its mode. The update is visible on the cycle after the write, and other channels are unaffected.
- R3: A mode code of 110 is stored as 010, and a mode code of 111 is stored as 011. Codes 000 to 101 are stored unchanged.
- R4: A control word whose format bits are 00, or whose channel bits are 11, changes no channel state. Bit 0 of a control word has no effect.
- R5: In format 01, each data write to the channel (`wr_sel` = channel number) loads a count of {0x00, data}.
- R6: In format 10, each data write to the channel loads a count of {data, 0x00}.
- R7: In format 11, the first data write stores the low byte and loads nothing. The next data write loads {data, stored low byte}, and the sequence then repeats.
- R8: A valid control word for a channel discards any pending low byte of that channel, so the next data write is again taken as the low byte.
- R9: Data writes to a channel that has received no valid control word since reset produce no strobe and leave its count unchanged.
- R10: Data writes never change any channel's mode or format.
- R11: A load raises that channel's `ld_strobe` bit for exactly the one cycle after the completing write, and updates `ld_count` on that same cycle. `ld_count` then holds its value until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write valid for this cycle |
| wr_sel | input | 2 | 0 to 2 select a channel data port, 3 selects the control port |
| wr_data | input | 8 | Write byte |
| ch_mode | output | 9 | Stored mode, 3 bits per channel, channel 0 in bits 2:0 |
| ch_fmt | output | 6 | Stored format, 2 bits per channel, 00 means not yet programmed |
| ld_strobe | output | 3 | One-cycle load pulse, one bit per channel |
| ld_count | output | 48 | Initial count, 16 bits per channel, channel 0 in bits 15:0 |

## Verification
The hardest case to reach is a two-byte sequence that a control word interrupts. The low byte has been taken, and the re-programming must drop it without producing a load. The directed stimulus writes a lone low byte, then reprograms the channel, then sends a full pair, and checks that the loaded value uses only the new pair. After the directed steps, a long run of random writes mixes control words, latch-code words, writes with channel field 3 and writes to unarmed channels. A behavioural model checks these on every clock, so that toggles left in many different states are compared against fresh control words.

// File: rtl/tmr_prog_if.sv
module tmr_prog_if #(
  parameter int NCH = 3,
  parameter int BW  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [BW-1:0]        wr_data,
  output logic [NCH*3-1:0]     ch_mode,
  output logic [NCH*2-1:0]     ch_fmt,
  output logic [NCH-1:0]       ld_strobe,
  output logic [NCH*2*BW-1:0]  ld_count
);
  localparam int CW = 2 * BW;
  localparam logic [1:0] CTRL_SEL = 2'd3;

  wire       ctl_wr   = wr_en && (wr_sel == CTRL_SEL);
  wire [1:0] ctl_ch   = wr_data[7:6];
  wire [1:0] ctl_fmt  = wr_data[5:4];
  wire [2:0] ctl_mode = {wr_data[3] & ~wr_data[2], wr_data[2:1]};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [2:0]    mode_q;
    logic [1:0]    fmt_q;
    logic          hi_q;
    logic [BW-1:0] lo_q;
    logic          stb_q;
    logic [CW-1:0] cnt_q;

    wire cw_hit = ctl_wr && (ctl_ch == 2'(i)) && (ctl_fmt != 2'b00);
    wire dw_hit = wr_en && (wr_sel == 2'(i)) && (fmt_q != 2'b00);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_q <= '0;
        fmt_q  <= '0;
        hi_q   <= 1'b0;
        lo_q   <= '0;
        stb_q  <= 1'b0;
        cnt_q  <= '0;
      end else begin
        stb_q <= 1'b0;
        if (cw_hit) begin
          mode_q <= ctl_mode;
          fmt_q  <= ctl_fmt;
          hi_q   <= 1'b0;
        end else if (dw_hit) begin
          unique case (fmt_q)
            2'b01: begin
              cnt_q <= {{BW{1'b0}}, wr_data};
              stb_q <= 1'b1;
            end
            2'b10: begin
              cnt_q <= {wr_data, {BW{1'b0}}};
              stb_q <= 1'b1;
            end
            default: begin
              if (hi_q) begin
                cnt_q <= {wr_data, lo_q};
                stb_q <= 1'b1;
                hi_q  <= 1'b0;
              end else begin
                lo_q <= wr_data;
                hi_q <= 1'b1;
              end
            end
          endcase
        end
      end
    end

    assign ch_mode[i*3 +: 3]    = mode_q;
    assign ch_fmt[i*2 +: 2]     = fmt_q;
    assign ld_strobe[i]         = stb_q;
    assign ld_count[i*CW +: CW] = cnt_q;
  end
endmodule

// File: rtl/tmr_prog_if_chk.sv
module tmr_prog_if_chk #(
  parameter int NCH = 3,
  parameter int BW  = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [1:0]          wr_sel,
  input logic [BW-1:0]       wr_data,
  input logic [NCH*3-1:0]    ch_mode,
  input logic [NCH*2-1:0]    ch_fmt,
  input logic [NCH-1:0]      ld_strobe,
  input logic [NCH*2*BW-1:0] ld_count
);
  localparam int CW = 2 * BW;

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ld_strobe)); // R11
  AST_MODE_HELD_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != 2'd3) |=> ($stable(ch_mode) && $stable(ch_fmt))); // R10

  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_strobe[i] |-> $past(wr_en && wr_sel == 2'(i))); // R11
    AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ld_strobe[i] |-> (ch_fmt[i*2 +: 2] != 2'b00)); // R9
    AST_MODE_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
      ch_mode[i*3 +: 3] <= 3'd5); // R3
    AST_LOW_ONLY_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_strobe[i] && ch_fmt[i*2 +: 2] == 2'b01) |-> (ld_count[i*CW+BW +: BW] == '0)); // R5
    AST_HIGH_ONLY_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_strobe[i] && ch_fmt[i*2 +: 2] == 2'b10) |-> (ld_count[i*CW +: BW] == '0)); // R6
    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_strobe[i] |-> $stable(ld_count[i*CW +: CW])); // R11
  end
endmodule

bind tmr_prog_if tmr_prog_if_chk #(.NCH(NCH), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ch_mode(ch_mode), .ch_fmt(ch_fmt), .ld_strobe(ld_strobe), .ld_count(ld_count)
);

// File: tb/sim_tmr_prog_if.sv
module sim_tmr_prog_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [8:0]  ch_mode;
  logic [5:0]  ch_fmt;
  logic [2:0]  ld_strobe;
  logic [47:0] ld_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_mode[3], m_fmt[3], m_hi[3], m_lo[3], m_cnt[3], m_stb[3];

  tmr_prog_if u0 (.*);

  always #4 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        m_mode[c] = 0; m_fmt[c] = 0; m_hi[c] = 0; m_lo[c] = 0; m_cnt[c] = 0; m_stb[c] = 0;
      end
    end else begin
      for (int c = 0; c < 3; c++) m_stb[c] = 0;
      if (wr_en) begin
        if (wr_sel == 2'd3) begin
          int c, f, md;
          c = int'(wr_data) / 64;
          f = (int'(wr_data) / 16) % 4;
          md = (int'(wr_data) / 2) % 8;
          if (md >= 6) md -= 4;
          if (c < 3 && f != 0) begin
            m_mode[c] = md; m_fmt[c] = f; m_hi[c] = 0;
          end
        end else begin
          int c;
          c = int'(wr_sel);
          if (m_fmt[c] == 1) begin
            m_cnt[c] = int'(wr_data); m_stb[c] = 1;
          end else if (m_fmt[c] == 2) begin
            m_cnt[c] = int'(wr_data) * 256; m_stb[c] = 1;
          end else if (m_fmt[c] == 3) begin
            if (m_hi[c] != 0) begin
              m_cnt[c] = int'(wr_data) * 256 + m_lo[c]; m_stb[c] = 1; m_hi[c] = 0;
            end else begin
              m_lo[c] = int'(wr_data); m_hi[c] = 1;
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      for (int c = 0; c < 3; c++) begin
        check("R2/R3/R4/R10 mode", int'(ch_mode[c*3 +: 3]), m_mode[c]);
        check("R2/R4/R10 format", int'(ch_fmt[c*2 +: 2]), m_fmt[c]);
        check("R9/R11 strobe", int'(ld_strobe[c]), m_stb[c]);
        check("R5/R6/R7/R8 count", int'(ld_count[c*16 +: 16]), m_cnt[c]);
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    wr_en = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset strobe", int'(ld_strobe), 0);
    check("R1 reset count", int'(ld_count != 0), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset mode", int'(ch_mode), 0);
    check("R1 after reset format", int'(ch_fmt), 0);

    wr(2'd1, 8'h5A); wr(2'd1, 8'hA5); idle(1);
    @(negedge clk);
    check("R9 unarmed count", int'(ld_count[31:16]), 0);

    wr(2'd3, 8'h34); wr(2'd0, 8'hCD); wr(2'd0, 8'hAB); idle(0);
    @(negedge clk);
    check("R7 two-byte count", int'(ld_count[15:0]), 16'hABCD);

    wr(2'd3, 8'h16); wr(2'd0, 8'h55); idle(0);
    @(negedge clk);
    check("R5 low-only count", int'(ld_count[15:0]), 16'h0055);
    check("R2 ch0 mode", int'(ch_mode[2:0]), 3);

    wr(2'd3, 8'h66); wr(2'd1, 8'h12); idle(0);
    @(negedge clk);
    check("R6 high-only count", int'(ld_count[31:16]), 16'h1200);

    wr(2'd3, 8'hBC); idle(1);
    @(negedge clk);
    check("R3 mode 6 folds", int'(ch_mode[8:6]), 2);
    wr(2'd3, 8'hBF); idle(1);
    @(negedge clk);
    check("R3 mode 7 folds, R4 bit0", int'(ch_mode[8:6]), 3);

    wr(2'd3, 8'h80); wr(2'd3, 8'hC4); idle(1);
    @(negedge clk);
    check("R4 latch code ignored", int'(ch_mode[8:6]), 3);
    check("R4 select 3 ignored fmt", int'(ch_fmt[5:4]), 3);

    wr(2'd2, 8'h11); wr(2'd3, 8'hB4); wr(2'd2, 8'h22); wr(2'd2, 8'h33); idle(0);
    @(negedge clk);
    check("R8 reprogram drops low byte", int'(ld_count[47:32]), 16'h3322);

    wr(2'd2, 8'h01); wr(2'd2, 8'h02); idle(1);
    @(negedge clk);
    check("R10 mode kept after data", int'(ch_mode[8:6]), 2);

    for (int k = 0; k < 3000; k++) begin
      logic [1:0] s;
      logic [7:0] d;
      s = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        @(posedge clk); #1; wr_en = 1'b0;
      end else begin
        wr(s, d);
      end
    end
    idle(2);

    rst_n = 1'b0;
    idle(2);
    @(negedge clk);
    check("R1 re-reset count", int'(ld_count != 0), 0);
    #1 rst_n = 1'b1;
    idle(2);
    finish_run();
  end
endmodule